// File: doc/BRIEF.md
# Expansion Address Space Allocator

The allocator hands out base addresses to a chain of expansion units while the system starts up. All addresses come from one fixed 8 MiB window, 0x20_0000 through 0x9F_FFFF. Each unit asks for a power-of-two amount of space, given in 64 KiB granules. A board that offers a size that is not a power of two shows up as several units; for example, 6 MiB becomes a 4 MiB unit followed by a 2 MiB unit. Units are handled strictly in chain position order, so units in the processor slot, which take the low positions, are served before units on the expansion bus.

After reset release the block examines one chain position per clock. A present unit whose request fits is given the lowest base that is aligned to its size, measured from the window start, at or above the end of the last unit placed. Any gap that alignment leaves is skipped. A unit that cannot be placed is told to stay silent and receives no address. The space pointer does not move in that case, so a smaller unit later in the chain can still use the space. Each position raises its hand-off output once it has been handled, and that output passes configuration on to the next position. When the last position has been handled a done flag rises. The block then keeps all of its results until the next reset.

Top module: `alloc`

## Requirements
- R1: While reset is asserted, every unit output, every base output and the done output are 0.
- R2: Position i is handled at the (i+1)-th rising clock edge after reset release. Its hand-off bit `unit_cfgout_o[i]` rises then, and the hand-off bits always form a contiguous run starting from position 0.
- R3: A present unit with a legal size that fits gets `unit_en_o=1` and a base equal to 0x20_0000 plus its offset. The offset is a multiple of the unit's size, both counted in 64 KiB granules.
- R4: Placement is first-come. Each placed unit takes the lowest size-aligned offset at or above the end of the previously placed unit, and any alignment gap is left unused.
- R5: A present unit whose aligned placement would pass the window end gets `unit_off_o=1`, `unit_en_o=0` and base 0. The free pointer is unchanged, so a later smaller unit can still fit.
- R6: A size of 0, a size above 128 granules (8 MiB), or a size that is not a power of two is treated as not fitting, with the same result as R5.
- R7: A position whose request bit is 0 is handed off with neither enable nor shut-off set, base 0, and the free pointer unchanged.
- R8: Every assigned range lies within 0x20_0000..0x9F_FFFF, so no base uses bits above the 24-bit range.
- R9: `done_o` rises at the NUM_UNITS-th edge after reset release, together with the last hand-off bit. After that, all outputs hold whatever the inputs do, until reset.
- R10: A unit never has both enable and shut-off set, and neither flag is set before its hand-off bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| unit_req_i | input | NUM_UNITS | Per position: a unit is present and requesting space |
| unit_size_i | input | NUM_UNITS x SIZE_W | Per position: requested size in 64 KiB granules |
| unit_base_o | output | NUM_UNITS x 24 | Per position: assigned base address (0 if none) |
| unit_en_o | output | NUM_UNITS | Per position: unit was placed and enabled |
| unit_off_o | output | NUM_UNITS | Per position: unit was commanded silent |
| unit_cfgout_o | output | NUM_UNITS | Per position: configuration handed off past this unit |
| done_o | output | 1 | Every position has been handled |

## Verification
Position i's result is registered at the (i+1)-th rising edge after reset release, and done follows at edge NUM_UNITS. Inputs are changed and outputs are sampled on falling edges. The timing scenario checks the hand-off count and done after each single edge. The placement scenarios check every position's enable, shut-off and base NUM_UNITS+1 falling edges after release, when the last result is certainly in place. The hold check changes all inputs after done and samples again three edges later.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
    localparam int ADDR_W = 24;

    function automatic logic is_pow2(input logic [31:0] v);
        return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
    endfunction
endpackage

// File: rtl/alloc_size_decode.sv
module alloc_size_decode #(
    parameter int SIZE_W    = 9,
    parameter int WIN_GRANS = 128
) (
    input  logic [SIZE_W-1:0] size_i,
    output logic              legal_o
);
    import alloc_pkg::*;

    always_comb begin
        legal_o = is_pow2(32'(size_i)) && (32'(size_i) <= 32'(WIN_GRANS));
    end
endmodule

// File: rtl/alloc_align_fit.sv
module alloc_align_fit #(
    parameter int SIZE_W    = 9,
    parameter int OFF_W     = 8,
    parameter int WIN_GRANS = 128
) (
    input  logic [OFF_W-1:0]  free_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [OFF_W-1:0]  aligned_o,
    output logic [OFF_W-1:0]  next_free_o,
    output logic              fits_o
);
    localparam int CW = ((SIZE_W > OFF_W) ? SIZE_W : OFF_W) + 2;

    logic [CW-1:0] sz_w;
    logic [CW-1:0] mask_w;
    logic [CW-1:0] up_w;
    logic [CW-1:0] end_w;

    always_comb begin
        sz_w        = CW'(size_i);
        mask_w      = ~(sz_w - CW'(1));
        up_w        = (CW'(free_i) + sz_w - CW'(1)) & mask_w;
        end_w       = up_w + sz_w;
        fits_o      = (end_w <= CW'(WIN_GRANS));
        aligned_o   = OFF_W'(up_w);
        next_free_o = OFF_W'(end_w);
    end
endmodule

// File: rtl/alloc.sv
module alloc #(
    parameter int                 NUM_UNITS = 6,
    parameter int                 SIZE_W    = 9,
    parameter int                 WIN_GRANS = 128,
    parameter int                 GRAN_LOG2 = 16,
    parameter logic [23:0]        WIN_BASE  = 24'h20_0000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_UNITS-1:0]             unit_req_i,
    input  logic [NUM_UNITS-1:0][SIZE_W-1:0] unit_size_i,
    output logic [NUM_UNITS-1:0][23:0]       unit_base_o,
    output logic [NUM_UNITS-1:0]             unit_en_o,
    output logic [NUM_UNITS-1:0]             unit_off_o,
    output logic [NUM_UNITS-1:0]             unit_cfgout_o,
    output logic                             done_o
);
    import alloc_pkg::*;

    localparam int OFF_W = $clog2(WIN_GRANS + 1);
    localparam int IDX_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_UNITS - 1);

    typedef struct packed {
        logic [IDX_W-1:0]                idx;
        logic [OFF_W-1:0]                free;
        logic [NUM_UNITS-1:0]            handed;
        logic [NUM_UNITS-1:0]            en;
        logic [NUM_UNITS-1:0]            off;
        logic [NUM_UNITS-1:0][ADDR_W-1:0] base;
        logic                            done;
    } alloc_state_t;

    alloc_state_t st_d, st_q;

    logic              cur_req;
    logic [SIZE_W-1:0] cur_size;
    logic              cur_legal;
    logic [OFF_W-1:0]  cur_aligned;
    logic [OFF_W-1:0]  cur_next;
    logic              cur_fits;

    always_comb begin
        cur_req  = unit_req_i[st_q.idx];
        cur_size = unit_size_i[st_q.idx];
    end

    alloc_size_decode #(
        .SIZE_W   (SIZE_W),
        .WIN_GRANS(WIN_GRANS)
    ) u_dec (
        .size_i (cur_size),
        .legal_o(cur_legal)
    );

    alloc_align_fit #(
        .SIZE_W   (SIZE_W),
        .OFF_W    (OFF_W),
        .WIN_GRANS(WIN_GRANS)
    ) u_fit (
        .free_i     (st_q.free),
        .size_i     (cur_size),
        .aligned_o  (cur_aligned),
        .next_free_o(cur_next),
        .fits_o     (cur_fits)
    );

    // Next-state: one chain position per cycle until done
    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.handed[st_q.idx] = 1'b1;
            if (cur_req) begin
                if (cur_legal && cur_fits) begin
                    st_d.en[st_q.idx]   = 1'b1;
                    st_d.base[st_q.idx] = WIN_BASE + (ADDR_W'(cur_aligned) << GRAN_LOG2);
                    st_d.free           = cur_next;
                end else begin
                    st_d.off[st_q.idx]  = 1'b1;
                end
            end
            if (st_q.idx == LAST_IDX) begin
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unit_base_o   = st_q.base;
        unit_en_o     = st_q.en;
        unit_off_o    = st_q.off;
        unit_cfgout_o = st_q.handed;
        done_o        = st_q.done;
    end
endmodule

// File: rtl/alloc_chk.sv
module alloc_chk #(
    parameter int          NUM_UNITS = 6,
    parameter int          WIN_GRANS = 128,
    parameter int          GRAN_LOG2 = 16,
    parameter logic [23:0] WIN_BASE  = 24'h20_0000
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_UNITS-1:0][23:0] unit_base_o,
    input logic [NUM_UNITS-1:0]       unit_en_o,
    input logic [NUM_UNITS-1:0]       unit_off_o,
    input logic [NUM_UNITS-1:0]       unit_cfgout_o,
    input logic                       done_o
);
    localparam logic [23:0] TOP_GRAN = WIN_BASE + 24'((WIN_GRANS - 1) << GRAN_LOG2);

    // R2: exactly one more position handed off per cycle until done
    a_r2_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> ($countones(unit_cfgout_o) == $countones($past(unit_cfgout_o)) + 1));

    // R9: done coincides with the last hand-off, and results hold afterwards
    a_r9_done_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> unit_cfgout_o[NUM_UNITS-1]);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && $stable(unit_base_o) && $stable(unit_en_o)
                    && $stable(unit_off_o) && $stable(unit_cfgout_o)));

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        if (i > 0) begin : g_order
            // R2: hand-off bits form a contiguous run from position 0
            a_r2_chain_order: assert property (@(posedge clk) disable iff (!rst_n)
                unit_cfgout_o[i] |-> unit_cfgout_o[i-1]);
        end

        // R10: enable and shut-off are exclusive and follow the hand-off
        a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(unit_en_o[i] && unit_off_o[i]));

        a_r10_after_handoff: assert property (@(posedge clk) disable iff (!rst_n)
            (unit_en_o[i] || unit_off_o[i]) |-> unit_cfgout_o[i]);

        // R8: assigned bases stay inside the window
        a_r8_in_window: assert property (@(posedge clk) disable iff (!rst_n)
            unit_en_o[i] |-> (unit_base_o[i] >= WIN_BASE && unit_base_o[i] <= TOP_GRAN));

        // R5: a silenced unit carries no address
        a_r5_no_base: assert property (@(posedge clk) disable iff (!rst_n)
            !unit_en_o[i] |-> (unit_base_o[i] == 24'h0));
    end
endmodule

bind alloc alloc_chk #(
    .NUM_UNITS(NUM_UNITS),
    .WIN_GRANS(WIN_GRANS),
    .GRAN_LOG2(GRAN_LOG2),
    .WIN_BASE (WIN_BASE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .unit_base_o  (unit_base_o),
    .unit_en_o    (unit_en_o),
    .unit_off_o   (unit_off_o),
    .unit_cfgout_o(unit_cfgout_o),
    .done_o       (done_o)
);

// File: tb/alloc_tb.sv
`timescale 1ns/1ps
module alloc_tb;
    localparam int N      = 6;
    localparam int SIZE_W = 9;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [N-1:0]             req;
    logic [N-1:0][SIZE_W-1:0] sz;
    logic [N-1:0][23:0]       base;
    logic [N-1:0]             en;
    logic [N-1:0]             off;
    logic [N-1:0]             cfgout;
    logic                     done;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    alloc #(.NUM_UNITS(N), .SIZE_W(SIZE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .unit_req_i(req), .unit_size_i(sz),
        .unit_base_o(base), .unit_en_o(en), .unit_off_o(off),
        .unit_cfgout_o(cfgout), .done_o(done)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic chk_unit(input string tag, input int i, input logic e,
                            input logic s, input logic [23:0] b);
        chk($sformatf("%s u%0d en", tag, i), 32'(en[i]), 32'(e));
        chk($sformatf("%s u%0d off", tag, i), 32'(off[i]), 32'(s));
        chk($sformatf("%s u%0d base", tag, i), 32'(base[i]), 32'(b));
    endtask

    task automatic run_chain();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (N + 1) @(negedge clk);
    endtask

    task automatic set_units(input logic [N-1:0] r, input int s0, input int s1,
                             input int s2, input int s3, input int s4, input int s5);
        req = r;
        sz[0] = SIZE_W'(s0); sz[1] = SIZE_W'(s1); sz[2] = SIZE_W'(s2);
        sz[3] = SIZE_W'(s3); sz[4] = SIZE_W'(s4); sz[5] = SIZE_W'(s5);
    endtask

    // R1: outputs cleared while reset is held
    task automatic t_reset();
        set_units(6'b111111, 1, 1, 1, 1, 1, 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 en", 32'(en), 0);
        chk("R1 off", 32'(off), 0);
        chk("R1 cfgout", 32'(cfgout), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 base0", 32'(base[0]), 0);
    endtask

    // R3 R5: two 4 MiB units fill the window, a 2 MiB one is silenced
    task automatic t_fill();
        set_units(6'b000111, 64, 64, 32, 0, 0, 0);
        run_chain();
        chk_unit("R3 fill", 0, 1'b1, 1'b0, 24'h20_0000);
        chk_unit("R3 fill", 1, 1'b1, 1'b0, 24'h60_0000);
        chk_unit("R5 full", 2, 1'b0, 1'b1, 24'h0);
        chk("R9 done fill", 32'(done), 1);
    endtask

    // R4 R5: alignment gaps skipped, shut-off keeps pointer for later unit
    task automatic t_gaps();
        set_units(6'b011111, 1, 32, 8, 64, 16, 0);
        run_chain();
        chk_unit("R4 gap", 0, 1'b1, 1'b0, 24'h20_0000);
        chk_unit("R4 gap", 1, 1'b1, 1'b0, 24'h40_0000);
        chk_unit("R4 gap", 2, 1'b1, 1'b0, 24'h60_0000);
        chk_unit("R5 nofit", 3, 1'b0, 1'b1, 24'h0);
        chk_unit("R5 later", 4, 1'b1, 1'b0, 24'h70_0000);
        chk_unit("R7 empty", 5, 1'b0, 1'b0, 24'h0);
    endtask

    // R6 R8: illegal sizes silenced, full 8 MiB unit at window start
    task automatic t_bad_sizes();
        set_units(6'b111111, 0, 200, 3, 128, 1, 129);
        run_chain();
        chk_unit("R6 zero", 0, 1'b0, 1'b1, 24'h0);
        chk_unit("R6 big", 1, 1'b0, 1'b1, 24'h0);
        chk_unit("R6 npow2", 2, 1'b0, 1'b1, 24'h0);
        chk_unit("R8 whole", 3, 1'b1, 1'b0, 24'h20_0000);
        chk_unit("R5 after8M", 4, 1'b0, 1'b1, 24'h0);
        chk_unit("R6 129", 5, 1'b0, 1'b1, 24'h0);
    endtask

    // R7: absent positions consume no space
    task automatic t_absent();
        set_units(6'b001010, 128, 32, 128, 32, 0, 0);
        run_chain();
        chk_unit("R7 abs", 0, 1'b0, 1'b0, 24'h0);
        chk_unit("R7 pres", 1, 1'b1, 1'b0, 24'h20_0000);
        chk_unit("R7 abs", 2, 1'b0, 1'b0, 24'h0);
        chk_unit("R7 pres", 3, 1'b1, 1'b0, 24'h40_0000);
        chk("R7 cfgout all", 32'(cfgout), 32'h3F);
    endtask

    // R2 R9: per-edge hand-off, done timing, hold after done
    task automatic t_timing_hold();
        set_units(6'b000111, 64, 64, 32, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 1; k <= N + 2; k++) begin
            int m;
            @(negedge clk);
            m = (k < N) ? k : N;
            chk($sformatf("R2 cfgout edge %0d", k), 32'(cfgout), (32'd1 << m) - 32'd1);
            chk($sformatf("R9 done edge %0d", k), 32'(done), (k >= N) ? 32'd1 : 32'd0);
        end
        set_units(6'b111111, 1, 1, 1, 1, 1, 1);
        repeat (3) @(negedge clk);
        chk_unit("R9 hold", 0, 1'b1, 1'b0, 24'h20_0000);
        chk_unit("R9 hold", 2, 1'b0, 1'b1, 24'h0);
        chk_unit("R9 hold", 3, 1'b0, 1'b0, 24'h0);
        chk("R9 hold done", 32'(done), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_gaps();
        t_bad_sizes();
        t_absent();
        t_timing_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule